// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block keeps a 64-bit signed accumulator, stored as a high half and a low half, and adds a signed product to it on each operation strobe. Two operand widths are offered: a long operation that multiplies two full signed 32-bit operands, and a word operation that multiplies only the signed low 16 bits of each operand. A saturation-mode input, sampled with the strobe, decides how the sum is clipped before it is stored.

Each operand width clips in its own way. In long mode the high half is limited to a 48-bit signed range: the upper bits are sign-filled when the sum is negative and cleared down to bit 15 when it is not. The low half keeps the raw bits. In word mode the result is limited to the signed 32-bit range: an overflow stores the nearest 32-bit limit in the low half and places the value 1 in the high half as an overflow marker. With saturation off, both modes store the plain wrapping 64-bit sum.

Software or a sequencer can load either half directly through its own write port, can zero both halves with a clear command, and can read both halves at any time. Each operation takes one cycle. The result appears on the read ports after the clock edge that samples the strobe.

Top module: `sat_mac`

## Requirements
- R1: A synchronous active-low reset sets both accumulator halves to zero.
- R2: A clear command sets both halves to zero at the next edge. It takes priority over an operation strobe and over any half write in the same cycle.
- R3: With `op_sel` = 0 (long), the unit sign-extends both 32-bit operands, forms their full signed 64-bit product and adds it to {acc_hi, acc_lo}.
- R4: With `op_sel` = 1 (word), only bits 15:0 of each operand take part, as signed 16-bit values. Bits 31:16 of both operands have no effect on the result.
- R5: In long mode with saturation on, a negative 64-bit sum sets acc_hi[31:16] to all ones and a non-negative sum clears acc_hi[31:15]. The remaining high bits and all of acc_lo keep the raw sum bits.
- R6: In word mode with saturation on, a sum below -2^31 stores acc_hi = 1 and acc_lo = 0x80000000.
- R7: In word mode with saturation on, a sum above 2^31-1 stores acc_hi = 1 and acc_lo = 0x7FFFFFFF.
- R8: In word mode with saturation on, a sum from -2^31 to 2^31-1, both limits included, is stored as its raw 64-bit bits.
- R9: With saturation off, both modes store the 64-bit sum modulo 2^64.
- R10: `hi_we` and `lo_we` load their own half and leave the other half unchanged. An operation strobe in the same cycle takes priority over both writes.
- R11: The result of a strobe appears on the read ports after the next rising edge and not before. With no clear, strobe or write, both halves hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Operation strobe, one accumulate per cycle it is high |
| op_sel | input | 1 | Operand width: 0 long (32x32), 1 word (16x16) |
| sat_en | input | 1 | Saturation mode for the current operation |
| opnd_a | input | 32 | First multiplicand |
| opnd_b | input | 32 | Second multiplicand |
| clr | input | 1 | Zero both halves; highest priority |
| hi_we | input | 1 | Load the high half from hi_wdata |
| hi_wdata | input | 32 | Data for the high half |
| lo_we | input | 1 | Load the low half from lo_wdata |
| lo_wdata | input | 32 | Data for the low half |
| acc_hi | output | 32 | Accumulator bits 63:32 |
| acc_lo | output | 32 | Accumulator bits 31:0 |

## Verification
The assertions assume that strobe, clear, write enables and operation select are driven to known values on every edge after reset. They also assume that a saturating word operation produces either the overflow marker or a high half that sign-extends the low half. Because that property must hold whatever the accumulator held before, the stimulus loads the accumulator with arbitrary values through the write ports before each saturating operation. This includes preloads such as a high half of 0x123 that already lie outside the 32-bit range. The bench drives every input on the falling edge, so each sampled value is defined and settled. It preloads both halves before each table entry so that every sum lands just inside, exactly at, or just beyond the thresholds of interest.

// File: rtl/sat_mac_pkg.sv
// Package: shared types of the saturating multiply-accumulate unit.
// Assumes: the operand-width select is a single bit at the block edge.
package sat_mac_pkg;

    // Operand width chosen by the operation select input.
    typedef enum logic {
        OP_LONG = 1'b0,
        OP_WORD = 1'b1
    } op_e;

endpackage

// File: rtl/mac_product.sv
// Module: mac_product
// Forms the signed product of the two operands at full accumulator width.
// The long variant sign-extends the whole operand. The word variant
// sign-extends only the low WORD_W bits. One multiplier serves both widths:
// the operands are extended first and then selected.
// Assumes: ACC_W = 2*DATA_W and WORD_W < DATA_W.
module mac_product
    import sat_mac_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WORD_W = 16,
    localparam int ACC_W = 2 * DATA_W
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [ACC_W-1:0]  prod
);

    logic [ACC_W-1:0] a_long, b_long;
    logic [ACC_W-1:0] a_word, b_word;
    logic [ACC_W-1:0] a_sel, b_sel;

    // Sign-extend the operands for each width.
    always_comb begin
        a_long = {{DATA_W{a[DATA_W-1]}}, a};
        b_long = {{DATA_W{b[DATA_W-1]}}, b};
        a_word = {{(ACC_W-WORD_W){a[WORD_W-1]}}, a[WORD_W-1:0]};
        b_word = {{(ACC_W-WORD_W){b[WORD_W-1]}}, b[WORD_W-1:0]};
    end

    // Pick the operand pair for the requested width.
    always_comb begin
        a_sel = (op == OP_WORD) ? a_word : a_long;
        b_sel = (op == OP_WORD) ? b_word : b_long;
    end

    // The low ACC_W bits of the product of two sign-extended values are the signed product.
    always_comb begin
        prod = a_sel * b_sel;
    end

endmodule

// File: rtl/mac_saturate.sv
// Module: mac_saturate
// Applies the width-specific clipping rule to a 64-bit wrapped sum and
// splits the result into high and low halves.
// Long: the high half is sign-filled above bit WORD_W-1 (negative) or
// cleared from bit WORD_W-1 up (non-negative); the low half is raw.
// Word: the sum is limited to the signed DATA_W range; an overflow
// stores the nearest limit in the low half and 1 in the high half.
// Assumes: the sum is the already wrapped ACC_W-bit value.
module mac_saturate
    import sat_mac_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WORD_W = 16,
    localparam int ACC_W = 2 * DATA_W
) (
    input  logic [ACC_W-1:0]  sum,
    input  op_e               op,
    input  logic              sat_en,
    output logic [DATA_W-1:0] res_hi,
    output logic [DATA_W-1:0] res_lo
);

    localparam int FILL_W = DATA_W - WORD_W;
    localparam logic [DATA_W-1:0] OVF_MARK = {{(DATA_W-1){1'b0}}, 1'b1};
    localparam logic [DATA_W-1:0] POS_LIM  = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_LIM  = {1'b1, {(DATA_W-1){1'b0}}};

    logic                sum_neg;
    logic [DATA_W-1:0]   raw_hi, raw_lo;
    logic [DATA_W:0]     upper;
    logic                word_pos_ovf, word_neg_ovf;
    logic [DATA_W-1:0]   long_hi;

    // Split the sum and take its sign.
    always_comb begin
        sum_neg = sum[ACC_W-1];
        raw_hi  = sum[ACC_W-1:DATA_W];
        raw_lo  = sum[DATA_W-1:0];
        upper   = sum[ACC_W-1:DATA_W-1];
    end

    // Word-mode range test: bits above the DATA_W-bit value must all copy its sign.
    always_comb begin
        word_pos_ovf = !sum_neg && (|upper);
        word_neg_ovf =  sum_neg && !(&upper);
    end

    // Long-mode high half: 48-bit signed range kept in the high register.
    always_comb begin
        if (sum_neg) begin
            long_hi = {{FILL_W{1'b1}}, raw_hi[WORD_W-1:0]};
        end else begin
            long_hi = {{(FILL_W+1){1'b0}}, raw_hi[WORD_W-2:0]};
        end
    end

    // Select the final halves from the mode and saturation setting.
    always_comb begin
        res_hi = raw_hi;
        res_lo = raw_lo;
        if (sat_en) begin
            if (op == OP_LONG) begin
                res_hi = long_hi;
            end else if (word_pos_ovf) begin
                res_hi = OVF_MARK;
                res_lo = POS_LIM;
            end else if (word_neg_ovf) begin
                res_hi = OVF_MARK;
                res_lo = NEG_LIM;
            end
        end
    end

endmodule

// File: rtl/mac_acc_reg.sv
// Module: mac_acc_reg
// Holds the two accumulator halves. The sources are ranked from highest
// to lowest: reset, clear, accumulate update, then the per-half writes.
// Assumes: a synchronous active-low reset.
module mac_acc_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              upd,
    input  logic [DATA_W-1:0] upd_hi,
    input  logic [DATA_W-1:0] upd_lo,
    input  logic              hi_we,
    input  logic [DATA_W-1:0] hi_wdata,
    input  logic              lo_we,
    input  logic [DATA_W-1:0] lo_wdata,
    output logic [DATA_W-1:0] q_hi,
    output logic [DATA_W-1:0] q_lo
);

    // Register both halves under the fixed priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_hi <= '0;
            q_lo <= '0;
        end else if (clr) begin
            q_hi <= '0;
            q_lo <= '0;
        end else if (upd) begin
            q_hi <= upd_hi;
            q_lo <= upd_lo;
        end else begin
            if (hi_we) q_hi <= hi_wdata;
            if (lo_we) q_lo <= lo_wdata;
        end
    end

endmodule

// File: rtl/sat_mac.sv
// Module: sat_mac (top)
// Single-cycle saturating multiply-accumulate. On a strobe, the product of
// the selected width is added to {acc_hi, acc_lo}. The sum is clipped by
// the width-specific rule and registered at the next rising edge.
// Assumes: inputs are synchronous to clk; one operation per cycle at most.
module sat_mac
    import sat_mac_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WORD_W = 16,
    localparam int ACC_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_sel,
    input  logic              sat_en,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              clr,
    input  logic              hi_we,
    input  logic [DATA_W-1:0] hi_wdata,
    input  logic              lo_we,
    input  logic [DATA_W-1:0] lo_wdata,
    output logic [DATA_W-1:0] acc_hi,
    output logic [DATA_W-1:0] acc_lo
);

    op_e               op;
    logic [ACC_W-1:0]  prod;
    logic [ACC_W-1:0]  sum;
    logic [DATA_W-1:0] nxt_hi, nxt_lo;

    // Map the select pin to the operation type.
    always_comb begin
        op = op_e'(op_sel);
    end

    mac_product #(
        .DATA_W (DATA_W),
        .WORD_W (WORD_W)
    ) u_prod (
        .op   (op),
        .a    (opnd_a),
        .b    (opnd_b),
        .prod (prod)
    );

    // Add the product to the current accumulator, wrapping at ACC_W bits.
    always_comb begin
        sum = {acc_hi, acc_lo} + prod;
    end

    mac_saturate #(
        .DATA_W (DATA_W),
        .WORD_W (WORD_W)
    ) u_sat (
        .sum    (sum),
        .op     (op),
        .sat_en (sat_en),
        .res_hi (nxt_hi),
        .res_lo (nxt_lo)
    );

    mac_acc_reg #(
        .DATA_W (DATA_W)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .upd      (op_valid),
        .upd_hi   (nxt_hi),
        .upd_lo   (nxt_lo),
        .hi_we    (hi_we),
        .hi_wdata (hi_wdata),
        .lo_we    (lo_we),
        .lo_wdata (lo_wdata),
        .q_hi     (acc_hi),
        .q_lo     (acc_lo)
    );

endmodule

// File: rtl/sat_mac_chk.sv
// Module: sat_mac_chk
// Property checker attached to every sat_mac instance. It watches ports only.
// Assumes: control inputs are known on every edge after reset.
module sat_mac_chk #(
    parameter int DATA_W = 32,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              op_sel,
    input logic              sat_en,
    input logic              clr,
    input logic              hi_we,
    input logic [DATA_W-1:0] hi_wdata,
    input logic              lo_we,
    input logic [DATA_W-1:0] acc_hi,
    input logic [DATA_W-1:0] acc_lo
);

    localparam logic [DATA_W-1:0] OVF_MARK = {{(DATA_W-1){1'b0}}, 1'b1};
    localparam logic [DATA_W-1:0] POS_LIM  = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_LIM  = {1'b1, {(DATA_W-1){1'b0}}};

    // Reset empties the accumulator.
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (acc_hi == '0 && acc_lo == '0));

    // Clear wins over every other source.
    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_hi == '0 && acc_lo == '0));

    // Long saturation keeps the high half inside the 48-bit signed range.
    assert_long_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && op_valid && !op_sel && sat_en) |=>
        (acc_hi[DATA_W-1:WORD_W-1] == '0 || (&acc_hi[DATA_W-1:WORD_W])));

    // Word saturation: overflow marker with a limit (R6, R7), or an in-range sign-extended value.
    assert_word_form_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && op_valid && op_sel && sat_en) |=>
        ((acc_hi == OVF_MARK && (acc_lo == POS_LIM || acc_lo == NEG_LIM)) ||
         (acc_hi == {DATA_W{acc_lo[DATA_W-1]}})));

    // A high-half write loads the data and leaves the low half alone.
    assert_hi_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !op_valid && hi_we) |=> (acc_hi == $past(hi_wdata)));

    assert_lo_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !op_valid && hi_we && !lo_we) |=> $stable(acc_lo));

    // Without any command both halves hold.
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !op_valid && !hi_we && !lo_we) |=> ($stable(acc_hi) && $stable(acc_lo)));

endmodule

bind sat_mac sat_mac_chk #(
    .DATA_W (DATA_W),
    .WORD_W (WORD_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_sel   (op_sel),
    .sat_en   (sat_en),
    .clr      (clr),
    .hi_we    (hi_we),
    .hi_wdata (hi_wdata),
    .lo_we    (lo_we),
    .acc_hi   (acc_hi),
    .acc_lo   (acc_lo)
);

// File: tb/sat_mac_tb.sv
// Bench for sat_mac: a table of preload/operation vectors checked against a
// 64-bit signed reference, then directed tests for reset, priority and timing.
module sat_mac_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_sel = 1'b0;
    logic        sat_en = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        clr = 1'b0;
    logic        hi_we = 1'b0;
    logic [31:0] hi_wdata = '0;
    logic        lo_we = 1'b0;
    logic [31:0] lo_wdata = '0;
    logic [31:0] acc_hi, acc_lo;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sat_mac u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .sat_en(sat_en), .opnd_a(opnd_a), .opnd_b(opnd_b), .clr(clr),
        .hi_we(hi_we), .hi_wdata(hi_wdata), .lo_we(lo_we), .lo_wdata(lo_wdata),
        .acc_hi(acc_hi), .acc_lo(acc_lo)
    );

    typedef struct packed {
        logic [31:0] hi;
        logic [31:0] lo;
        logic        op;
        logic        sat;
        logic [31:0] a;
        logic [31:0] b;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0, 32'h0, 1'b0, 1'b0, 32'd3, 32'd5, 8'd3},                           // R3 small
        '{32'h0, 32'h0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'd7, 8'd3},                   // R3 negative
        '{32'h0, 32'h0, 1'b0, 1'b0, 32'h8000_0000, 32'h8000_0000, 8'd3},           // R3 full width
        '{32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'd1, 32'd1, 8'd9},           // R9 long wrap
        '{32'h0, 32'h0, 1'b1, 1'b0, 32'h1234_0003, 32'hABCD_0004, 8'd4},           // R4 upper ignored
        '{32'h0, 32'h0, 1'b1, 1'b0, 32'h0000_FFFF, 32'd2, 8'd4},                   // R4 signed low
        '{32'h0, 32'h0, 1'b0, 1'b1, 32'h8000_0000, 32'h7FFF_FFFF, 8'd5},           // R5 negative fill
        '{32'h0001_0000, 32'h0, 1'b0, 1'b1, 32'h0001_0000, 32'h0001_0000, 8'd5},   // R5 positive mask
        '{32'h0, 32'h0, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'd1, 8'd5},                   // R5 minus one
        '{32'h0, 32'h7FFF_FFF0, 1'b1, 1'b1, 32'd4, 32'd4, 8'd7},                   // R7 just above
        '{32'hFFFF_FFFF, 32'h8000_0005, 1'b1, 1'b1, 32'h0000_FFFF, 32'd6, 8'd6},   // R6 just below
        '{32'hFFFF_FFFF, 32'h8000_0006, 1'b1, 1'b1, 32'h0000_FFFF, 32'd6, 8'd8},   // R8 at low limit
        '{32'h0, 32'h7FFF_FFFE, 1'b1, 1'b1, 32'd1, 32'd1, 8'd8},                   // R8 at high limit
        '{32'h0, 32'h7FFF_FFF0, 1'b1, 1'b0, 32'd4, 32'd4, 8'd9},                   // R9 word no clip
        '{32'h0000_0123, 32'h0, 1'b1, 1'b1, 32'h0, 32'h0, 8'd7}                    // R7 preloaded big
    };

    // Reference: 64-bit signed arithmetic with the clipping rules.
    function automatic void ref_mac(input logic [31:0] hi, input logic [31:0] lo,
                                    input logic op, input logic sat,
                                    input logic [31:0] a, input logic [31:0] b,
                                    output logic [31:0] eh, output logic [31:0] el);
        longint acc, p, s;
        acc = longint'({hi, lo});
        if (!op) p = longint'($signed(a)) * longint'($signed(b));
        else     p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
        s  = acc + p;
        eh = s[63:32];
        el = s[31:0];
        if (sat) begin
            if (!op) begin
                if (s < 0) eh = eh | 32'hFFFF_0000;
                else       eh = eh & 32'h0000_7FFF;
            end else if (s < -64'sd2147483648) begin
                eh = 32'd1; el = 32'h8000_0000;
            end else if (s > 64'sd2147483647) begin
                eh = 32'd1; el = 32'h7FFF_FFFF;
            end
        end
    endfunction

    task automatic check(input string req, input logic [31:0] eh, input logic [31:0] el);
        n_checks++;
        if (acc_hi !== eh || acc_lo !== el) begin
            n_fail++;
            $display("FAIL %s: got %h_%h expected %h_%h", req, acc_hi, acc_lo, eh, el);
        end
    endtask

    task automatic load(input logic [31:0] h, input logic [31:0] l);
        @(negedge clk);
        hi_we = 1'b1; hi_wdata = h; lo_we = 1'b1; lo_wdata = l;
        @(negedge clk);
        hi_we = 1'b0; lo_we = 1'b0;
    endtask

    task automatic mac(input logic op, input logic sat, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_valid = 1'b1; op_sel = op; sat_en = sat; opnd_a = a; opnd_b = b;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        logic [31:0] eh, el;
        repeat (3) @(negedge clk);
        check("R1 reset", 32'h0, 32'h0);
        rst_n = 1'b1;

        // Table walk.
        for (int i = 0; i < NVEC; i++) begin
            load(VECS[i].hi, VECS[i].lo);
            mac(VECS[i].op, VECS[i].sat, VECS[i].a, VECS[i].b);
            ref_mac(VECS[i].hi, VECS[i].lo, VECS[i].op, VECS[i].sat, VECS[i].a, VECS[i].b, eh, el);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), eh, el);
        end

        // R11: result not visible before the edge, visible after, then held.
        load(32'h0, 32'h0);
        @(negedge clk);
        op_valid = 1'b1; op_sel = 1'b0; sat_en = 1'b0; opnd_a = 32'd2; opnd_b = 32'd3;
        #1 check("R11 before edge", 32'h0, 32'h0);
        @(negedge clk);
        op_valid = 1'b0;
        check("R11 after edge", 32'h0, 32'd6);
        repeat (3) @(negedge clk);
        check("R11 hold", 32'h0, 32'd6);

        // R3: back-to-back strobes accumulate.
        @(negedge clk);
        op_valid = 1'b1; opnd_a = 32'd2; opnd_b = 32'd3;
        @(negedge clk);
        opnd_a = 32'd4; opnd_b = 32'd5;
        @(negedge clk);
        op_valid = 1'b0;
        check("R3 back-to-back", 32'h0, 32'd32);

        // R10: per-half writes.
        @(negedge clk);
        hi_we = 1'b1; hi_wdata = 32'hCAFE_0001;
        @(negedge clk);
        hi_we = 1'b0;
        check("R10 high only", 32'hCAFE_0001, 32'd32);
        @(negedge clk);
        lo_we = 1'b1; lo_wdata = 32'h1234_5678;
        @(negedge clk);
        lo_we = 1'b0;
        check("R10 low only", 32'hCAFE_0001, 32'h1234_5678);

        // R10: a strobe beats both writes.
        load(32'h0, 32'd10);
        @(negedge clk);
        op_valid = 1'b1; op_sel = 1'b0; sat_en = 1'b0; opnd_a = 32'd1; opnd_b = 32'd1;
        hi_we = 1'b1; hi_wdata = 32'hDEAD_DEAD; lo_we = 1'b1; lo_wdata = 32'hBEEF_BEEF;
        @(negedge clk);
        op_valid = 1'b0; hi_we = 1'b0; lo_we = 1'b0;
        check("R10 strobe priority", 32'h0, 32'd11);

        // R2: clear alone, with a strobe, with writes.
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        check("R2 clear", 32'h0, 32'h0);
        load(32'h5, 32'h6);
        @(negedge clk);
        clr = 1'b1; op_valid = 1'b1; opnd_a = 32'd7; opnd_b = 32'd9;
        @(negedge clk);
        clr = 1'b0; op_valid = 1'b0;
        check("R2 clear over strobe", 32'h0, 32'h0);
        @(negedge clk);
        clr = 1'b1; hi_we = 1'b1; hi_wdata = 32'h77; lo_we = 1'b1; lo_wdata = 32'h88;
        @(negedge clk);
        clr = 1'b0; hi_we = 1'b0; lo_we = 1'b0;
        check("R2 clear over writes", 32'h0, 32'h0);

        // R1: reset in mid-run.
        load(32'hAAAA_5555, 32'h1357_9BDF);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 mid-run reset", 32'h0, 32'h0);

        finished = 1'b1;
        report();
    end

endmodule